// File: doc/BRIEF.md
# Event-to-Task Routing Crossbar

This block lets peripherals start one another's actions without the processor. Every peripheral raises single-cycle pulses on a shared event bus when something has happened, and every peripheral listens to a shared task bus for pulses that start an action. The crossbar sits between the two buses. It holds a set of channels. Each channel picks one event source and forwards its pulses to a primary task and to a secondary fork task. Because of the fork, one event can start two actions.

Channels are switched on and off one at a time through set and clear registers. They can also be switched in bulk through channel groups. Each group has an enable task and a disable task. These group tasks sit above the peripheral task numbers in the same select space, so a channel can route an event to a group task. This lets hardware change the routing while it runs. Configuration uses a simple single-cycle register bus with word addresses and a combinational read path.

Top module: `evt_xbar`

## Requirements
- R1: After reset, `task_o` is zero, every channel is disabled, every group mask reads zero, and every channel configuration reads 0x003F3F3F (all selects unconnected).
- R2: An enabled channel whose event select names source E forwards a pulse on `evt_i[E]` to its primary task. The pulse appears on `task_o` in the cycle after the event. Pulses on other sources produce nothing.
- R3: Any event source from 0 to 31 can be routed to any task from 0 to 31.
- R4: A channel also drives its fork task from the same event. If the primary and fork selects name the same task, that task receives a single pulse.
- R5: Each `task_o` bit is the OR of every enabled channel primary or fork that selects it and whose event fired.
- R6: A disabled channel forwards no pulses.
- R7: A select value of 63 means unconnected. An event select of 63 never fires, and a task or fork select of 63 drives no task.
- R8: Writing the enable register (address 0x00) replaces the enable vector. A 1 written at address 0x01 sets that channel's enable. A 1 written at address 0x02 clears it. A read of address 0x00, 0x01 or 0x02 returns the enable vector in bits 15:0.
- R9: Group g's membership mask sits at address 0x08+g, bits 15:0. A write to address 0x03 fires group tasks: bit g enables every member of group g, and bit 4+g disables every member. The change shows from the cycle after the write.
- R10: A task select of 32+g fires group g's enable task, and 36+g fires its disable task. A routed event changes the enable vector two cycles after the event pulse.
- R11: If an enable and a disable reach the same channel in the same cycle, from any mix of bus and routed sources, the channel ends up disabled.
- R12: Channel c's configuration sits at address 0x10+c. The event select is in bits 5:0, the primary task select in bits 13:8, and the fork select in bits 21:16. All other bits are ignored and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| evt_i | input | 32 | Event pulses from peripherals |
| task_o | output | 32 | Task pulses to peripherals, registered |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for `bus_addr_i` |

## Verification
The hardest case to reach is an enable and a disable landing on the same channel in the same cycle through the routed path. It only happens when one event is forked by a channel onto the enable task of one group and the disable task of another, and both groups contain the same channel. The bench builds that setup through the registers, fires the event, and reads the enable vector exactly two cycles later. It also reads the cycle in between, to show that the routed group task is not visible early.

// File: rtl/evt_xbar_pkg.sv
// Shared types and register addresses for the event-to-task crossbar.
// Assumes word-addressed registers with an 8-bit address.
package evt_xbar_pkg;

    localparam int SEL_W = 6;                       // select width; all ones = unconnected
    localparam logic [SEL_W-1:0] SEL_NONE = '1;

    localparam logic [7:0] ADDR_EN       = 8'h00;
    localparam logic [7:0] ADDR_SET      = 8'h01;
    localparam logic [7:0] ADDR_CLR      = 8'h02;
    localparam logic [7:0] ADDR_GRP_TASK = 8'h03;
    localparam int         ADDR_MASK_BASE = 8;
    localparam int         ADDR_CFG_BASE  = 16;

    typedef struct packed {
        logic [SEL_W-1:0] fork_sel;
        logic [SEL_W-1:0] task_sel;
        logic [SEL_W-1:0] evt_sel;
    } ch_cfg_t;

endpackage

// File: rtl/evt_xbar_chan.sv
// One routing channel: picks an event source and, when enabled, raises its
// primary and fork destination bits. Purely combinational.
// Assumes destination indices above the peripheral tasks are group tasks.
module evt_xbar_chan
    import evt_xbar_pkg::*;
#(
    parameter int N_EVT  = 32,
    parameter int N_DEST = 40
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_EVT-1:0]  evt_i,
    input  ch_cfg_t           cfg_i,
    input  logic              en_i,
    output logic [N_DEST-1:0] hit_o
);
    localparam int EW = $clog2(N_EVT);

    logic fire;

    // event qualification: enabled, select in range, source pulsing
    always_comb begin
        fire = en_i && (cfg_i.evt_sel < SEL_W'(N_EVT)) && evt_i[cfg_i.evt_sel[EW-1:0]];
    end

    // destination decode for primary and fork selects
    always_comb begin
        for (int d = 0; d < N_DEST; d++) begin
            hit_o[d] = fire && ((cfg_i.task_sel == SEL_W'(d)) || (cfg_i.fork_sel == SEL_W'(d)));
        end
    end

    AST_OFF_CHANNEL_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> (hit_o == '0)); // R6
    AST_UNCONNECTED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_i.task_sel == SEL_NONE && cfg_i.fork_sel == SEL_NONE) |-> (hit_o == '0)); // R7

endmodule

// File: rtl/evt_xbar_regs.sv
// Configuration registers: channel selects, group masks, and decode of the
// enable and group-task strobes. Read data is combinational from the address.
// Assumes N_GRP <= 8 and N_CH <= 16 so the fixed address windows do not overlap.
module evt_xbar_regs
    import evt_xbar_pkg::*;
#(
    parameter int N_CH  = 16,
    parameter int N_GRP = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             bus_wr_i,
    input  logic [7:0]       bus_addr_i,
    input  logic [31:0]      bus_wdata_i,
    output logic [31:0]      bus_rdata_o,
    input  logic [N_CH-1:0]  ch_en_i,
    output ch_cfg_t          cfg_o  [N_CH],
    output logic [N_CH-1:0]  mask_o [N_GRP],
    output logic             en_wr_o,
    output logic [N_CH-1:0]  en_wdata_o,
    output logic [N_CH-1:0]  set_o,
    output logic [N_CH-1:0]  clr_o,
    output logic [N_GRP-1:0] grp_en_o,
    output logic [N_GRP-1:0] grp_dis_o
);
    ch_cfg_t wcfg;
    logic    unused_wdata;

    // extract select fields from write data
    always_comb begin
        wcfg.evt_sel  = bus_wdata_i[SEL_W-1:0];
        wcfg.task_sel = bus_wdata_i[8 +: SEL_W];
        wcfg.fork_sel = bus_wdata_i[16 +: SEL_W];
    end
    assign unused_wdata = ^bus_wdata_i;

    // strobes for enable-vector writes and bus-fired group tasks
    always_comb begin
        en_wr_o    = bus_wr_i && (bus_addr_i == ADDR_EN);
        en_wdata_o = bus_wdata_i[N_CH-1:0];
        set_o      = (bus_wr_i && bus_addr_i == ADDR_SET) ? bus_wdata_i[N_CH-1:0] : '0;
        clr_o      = (bus_wr_i && bus_addr_i == ADDR_CLR) ? bus_wdata_i[N_CH-1:0] : '0;
        grp_en_o   = (bus_wr_i && bus_addr_i == ADDR_GRP_TASK) ? bus_wdata_i[N_GRP-1:0] : '0;
        grp_dis_o  = (bus_wr_i && bus_addr_i == ADDR_GRP_TASK) ? bus_wdata_i[N_GRP +: N_GRP] : '0;
    end

    // channel configuration storage, reset to unconnected
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int c = 0; c < N_CH; c++) cfg_o[c] <= '{SEL_NONE, SEL_NONE, SEL_NONE};
        end else if (bus_wr_i) begin
            for (int c = 0; c < N_CH; c++)
                if (bus_addr_i == 8'(ADDR_CFG_BASE + c)) cfg_o[c] <= wcfg;
        end
    end

    // group membership storage
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int g = 0; g < N_GRP; g++) mask_o[g] <= '0;
        end else if (bus_wr_i) begin
            for (int g = 0; g < N_GRP; g++)
                if (bus_addr_i == 8'(ADDR_MASK_BASE + g)) mask_o[g] <= bus_wdata_i[N_CH-1:0];
        end
    end

    // read multiplexer
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_EN || bus_addr_i == ADDR_SET || bus_addr_i == ADDR_CLR)
            bus_rdata_o = 32'(ch_en_i);
        for (int g = 0; g < N_GRP; g++)
            if (bus_addr_i == 8'(ADDR_MASK_BASE + g)) bus_rdata_o = 32'(mask_o[g]);
        for (int c = 0; c < N_CH; c++)
            if (bus_addr_i == 8'(ADDR_CFG_BASE + c))
                bus_rdata_o = {10'd0, cfg_o[c].fork_sel, 2'd0, cfg_o[c].task_sel,
                               2'd0, cfg_o[c].evt_sel};
    end

endmodule

// File: rtl/evt_xbar_enables.sv
// Channel enable vector. Merges bus writes, bus set/clear, and group tasks
// from the bus and from routed events. Clears beat sets in the same cycle.
// Assumes all incoming strobes are single-cycle pulses.
module evt_xbar_enables #(
    parameter int N_CH  = 16,
    parameter int N_GRP = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_wr_i,
    input  logic [N_CH-1:0]  en_wdata_i,
    input  logic [N_CH-1:0]  set_i,
    input  logic [N_CH-1:0]  clr_i,
    input  logic [N_GRP-1:0] bus_grp_en_i,
    input  logic [N_GRP-1:0] bus_grp_dis_i,
    input  logic [N_GRP-1:0] hw_grp_en_i,
    input  logic [N_GRP-1:0] hw_grp_dis_i,
    input  logic [N_CH-1:0]  mask_i [N_GRP],
    output logic [N_CH-1:0]  ch_en_o
);
    logic [N_CH-1:0] set_all;
    logic [N_CH-1:0] clr_all;

    // expand group tasks into per-channel set and clear masks
    always_comb begin
        set_all = set_i;
        clr_all = clr_i;
        for (int g = 0; g < N_GRP; g++) begin
            if (bus_grp_en_i[g]  || hw_grp_en_i[g])  set_all = set_all | mask_i[g];
            if (bus_grp_dis_i[g] || hw_grp_dis_i[g]) clr_all = clr_all | mask_i[g];
        end
    end

    // enable register update, disable has priority
    always_ff @(posedge clk_i) begin
        if (!rst_ni) ch_en_o <= '0;
        else         ch_en_o <= ((en_wr_i ? en_wdata_i : ch_en_o) | set_all) & ~clr_all;
    end

    AST_DISABLE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_all != '0) |=> ((ch_en_o & $past(clr_all)) == '0)); // R11
    AST_SET_TAKES_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((set_all & ~clr_all) != '0) |=>
        ((ch_en_o & $past(set_all & ~clr_all)) == $past(set_all & ~clr_all))); // R9

endmodule

// File: rtl/evt_xbar.sv
// Event-to-task crossbar top. Channels decode into a destination vector of
// peripheral tasks followed by group enable and group disable tasks. The OR of
// all channels is registered once, which gives the one-cycle event-to-task delay.
// Assumes N_TASK + 2*N_GRP < 2**SEL_W so the all-ones select stays unconnected.
module evt_xbar
    import evt_xbar_pkg::*;
#(
    parameter int N_EVT  = 32,
    parameter int N_TASK = 32,
    parameter int N_CH   = 16,
    parameter int N_GRP  = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [N_EVT-1:0]  evt_i,
    output logic [N_TASK-1:0] task_o,
    input  logic              bus_wr_i,
    input  logic [7:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o
);
    localparam int N_DEST = N_TASK + 2 * N_GRP;

    ch_cfg_t           cfg   [N_CH];
    logic [N_CH-1:0]   mask  [N_GRP];
    logic [N_DEST-1:0] hits  [N_CH];
    logic [N_DEST-1:0] dest_d, dest_q;
    logic [N_CH-1:0]   ch_en;
    logic              en_wr;
    logic [N_CH-1:0]   en_wdata, set_m, clr_m;
    logic [N_GRP-1:0]  bgrp_en, bgrp_dis;

    evt_xbar_regs #(.N_CH(N_CH), .N_GRP(N_GRP)) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .ch_en_i(ch_en), .cfg_o(cfg), .mask_o(mask),
        .en_wr_o(en_wr), .en_wdata_o(en_wdata), .set_o(set_m), .clr_o(clr_m),
        .grp_en_o(bgrp_en), .grp_dis_o(bgrp_dis)
    );

    evt_xbar_enables #(.N_CH(N_CH), .N_GRP(N_GRP)) enables_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .en_wr_i(en_wr), .en_wdata_i(en_wdata), .set_i(set_m), .clr_i(clr_m),
        .bus_grp_en_i(bgrp_en), .bus_grp_dis_i(bgrp_dis),
        .hw_grp_en_i(dest_q[N_TASK +: N_GRP]),
        .hw_grp_dis_i(dest_q[N_TASK + N_GRP +: N_GRP]),
        .mask_i(mask), .ch_en_o(ch_en)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        evt_xbar_chan #(.N_EVT(N_EVT), .N_DEST(N_DEST)) chan_i (
            .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .cfg_i(cfg[c]),
            .en_i(ch_en[c]), .hit_o(hits[c])
        );
    end

    // merge every channel's destinations
    always_comb begin
        dest_d = '0;
        for (int c = 0; c < N_CH; c++) dest_d = dest_d | hits[c];
    end

    // single output register stage for tasks and group tasks
    always_ff @(posedge clk_i) begin
        if (!rst_ni) dest_q <= '0;
        else         dest_q <= dest_d;
    end

    assign task_o = dest_q[N_TASK-1:0];

    AST_TASK_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (task_o != '0) |-> ($past(evt_i) != '0)); // R2
    AST_TASK_NEEDS_CHANNEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (task_o != '0) |-> ($past(ch_en) != '0)); // R6

endmodule

// File: tb/evt_xbar_tb.sv
`timescale 1ns/1ps
module evt_xbar_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic [31:0] tsk;
    logic        wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_xbar dut_i (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .task_o(tsk),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata)
    );

    // {evt_sel, task_sel, fork_sel, pulse source, expected task_o}
    localparam int NV = 8;
    localparam logic [54:0] VEC [NV] = '{
        {6'd3,  6'd7,  6'd63, 5'd3,  32'h0000_0080},   // R2
        {6'd10, 6'd4,  6'd63, 5'd11, 32'h0000_0000},   // R2 other source
        {6'd31, 6'd0,  6'd63, 5'd31, 32'h0000_0001},   // R3
        {6'd0,  6'd31, 6'd63, 5'd0,  32'h8000_0000},   // R3
        {6'd10, 6'd4,  6'd20, 5'd10, 32'h0010_0010},   // R4
        {6'd5,  6'd9,  6'd9,  5'd5,  32'h0000_0200},   // R4 same task
        {6'd63, 6'd1,  6'd2,  5'd31, 32'h0000_0000},   // R7 event select
        {6'd5,  6'd63, 6'd63, 5'd5,  32'h0000_0000}    // R7 task selects
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    function automatic logic [31:0] cfg_word(input logic [5:0] e, input logic [5:0] t,
                                             input logic [5:0] f);
        return {10'd0, f, 2'd0, t, 2'd0, e};
    endfunction

    // event pulse; returns at the negedge where task_o holds the result
    task automatic pulse(input logic [31:0] v);
        @(negedge clk); evt = v;
        @(negedge clk); evt = '0;
    endtask

    initial begin : watchdog
        #(8ns * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 task_o", tsk, 32'h0);
        bus_read(8'h01, r); check("R1 enables", r, 32'h0);
        bus_read(8'h08, r); check("R1 mask", r, 32'h0);
        bus_read(8'h1F, r); check("R1 cfg", r, 32'h003F_3F3F);

        bus_write(8'h01, 32'h1);
        for (int i = 0; i < NV; i++) begin
            logic [54:0] v;
            v = VEC[i];
            bus_write(8'h10, cfg_word(v[54:49], v[48:43], v[42:37]));
            pulse(32'h1 << v[36:32]);
            check($sformatf("R2/R3/R4/R7 vector %0d", i), tsk, v[31:0]);
            @(negedge clk);
            check($sformatf("R2 vector %0d single pulse", i), tsk, 32'h0);
        end

        bus_write(8'h15, 32'hFFEA_D5C7);
        bus_read(8'h15, r); check("R12 cfg fields", r, 32'h002A_1507);

        bus_write(8'h10, cfg_word(6'd2, 6'd6, 6'd63));
        bus_write(8'h11, cfg_word(6'd3, 6'd6, 6'd8));
        bus_write(8'h01, 32'h2);
        pulse(32'h4); check("R5 first channel", tsk, 32'h40);
        pulse(32'h8); check("R5 second channel", tsk, 32'h140);
        pulse(32'hC); check("R5 both channels", tsk, 32'h140);

        bus_write(8'h02, 32'h2);
        bus_read(8'h02, r); check("R8 clear read", r, 32'h1);
        pulse(32'h8); check("R6 disabled channel", tsk, 32'h0);

        bus_write(8'h01, 32'hF0);
        bus_read(8'h01, r); check("R8 set", r, 32'hF1);
        bus_write(8'h02, 32'h30);
        bus_read(8'h02, r); check("R8 clear", r, 32'hC1);
        bus_write(8'h00, 32'hFFFF_1234);
        bus_read(8'h00, r); check("R8 full write", r, 32'h1234);

        bus_write(8'h0A, 32'h0F00);
        bus_read(8'h0A, r); check("R9 mask read", r, 32'h0F00);
        bus_write(8'h00, 32'h1);
        bus_write(8'h03, 32'h04);
        bus_read(8'h01, r); check("R9 group enable", r, 32'h0F01);
        bus_write(8'h03, 32'h40);
        bus_read(8'h01, r); check("R9 group disable", r, 32'h0001);

        bus_write(8'h08, 32'h4);
        bus_write(8'h09, 32'h4);
        bus_write(8'h11, cfg_word(6'd5, 6'd32, 6'd63));
        bus_write(8'h00, 32'h2);
        pulse(32'h20);
        bus_read(8'h01, r); check("R10 not yet", r, 32'h2);
        @(negedge clk);
        bus_read(8'h01, r); check("R10 routed enable", r, 32'h6);
        bus_write(8'h11, cfg_word(6'd5, 6'd37, 6'd63));
        pulse(32'h20); @(negedge clk);
        bus_read(8'h01, r); check("R10 routed disable", r, 32'h2);

        bus_write(8'h00, 32'h6);
        bus_write(8'h03, 32'h21);
        bus_read(8'h01, r); check("R11 bus same cycle", r, 32'h2);
        bus_write(8'h11, cfg_word(6'd5, 6'd32, 6'd37));
        pulse(32'h20); @(negedge clk);
        bus_read(8'h01, r); check("R11 routed same cycle", r, 32'h2);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule